// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow host reach a 32-bit internal register space that sits behind a slower bus. The host writes byte-wide staging registers through a synchronous write strobe. Four bytes hold the write value. One address pair is used for writes and a second, separate pair is used for reads. The host then writes a command byte that holds a direction bit and a start bit. The bridge carries out exactly one 32-bit access on the internal bus. After a fixed, configurable number of cycles it clears the start bit by itself, and that bit doubles as the busy flag.

For a read, the 32-bit result is captured into four byte-wide result registers when the access completes. While an access is in flight, the bridge drops every host write to the staging and command registers, so only one operation can exist at a time. The host polls the command byte until the busy flag is low. It then reads the result bytes or issues the next command.

Top module: `ind_bridge`

## Requirements
- R1: After reset every host-visible byte (offsets 0 to 15) reads as 0, and `ib_stb` is low.
- R2: Host writes to offsets 0-3 (write value, offset 0 = bits 7:0), 4/5 (write address low/high) and 6/7 (read address low/high) are stored and read back unchanged while the bridge is idle.
- R3: Writing offset 8 with bit0 = 1 and bit1 = 0 starts a write. `ib_stb` pulses once with `ib_we` = 1, `ib_addr` = {offset 5, offset 4} and `ib_wdata` = {offset 3, offset 2, offset 1, offset 0}.
- R4: Writing offset 8 with bit0 = 1 and bit1 = 1 starts a read. `ib_stb` pulses once with `ib_we` = 0 and `ib_addr` = {offset 7, offset 6}. The `ib_rdata` value seen during that pulse becomes readable at offsets 9-12 (offset 9 = bits 7:0) from the next cycle, and these bytes change at no other time.
- R5: A write to offset 8 with bit0 = 0 has no effect: no access starts and the offset 8 readback is unchanged.
- R6: Offset 8 reads {6'b0, direction, busy}. Busy (bit0) is 1 from the cycle after the start command for exactly LATENCY cycles, then returns to 0 by itself.
- R7: While busy, host writes to offsets 0-8 are ignored: stored bytes keep their values and no further access is started.
- R8: `ib_stb` is high for exactly one cycle per accepted command, in the last busy cycle, LATENCY-1 cycles after busy rises.
- R9: Offsets 13-15 always read 0, and host writes to offsets 9-15 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host write strobe, one byte per cycle |
| h_addr | input | 4 | Host register offset for write and readback |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Readback byte at `h_addr` (combinational) |
| ib_stb | output | 1 | Internal access strobe, one cycle per operation |
| ib_we | output | 1 | Internal access is a write (valid with `ib_stb`) |
| ib_addr | output | 16 | Internal register address |
| ib_wdata | output | 32 | Internal write value |
| ib_rdata | input | 32 | Internal read value, sampled in the `ib_stb` cycle |

## Verification
A bad busy counter shows up at offset 8 within a cycle of the expected clear time, and it also shows as an `ib_stb` pulse that comes early, comes late, or is missing. A wrong direction or address selection appears on `ib_addr` and `ib_we` during the strobe cycle. A corrupted staging byte or a broken busy guard becomes visible in the next readback of that offset, or in the following strobe's address and data. A mislatched read result shows at offsets 9-12 one cycle after the strobe. For that reason the behavioural model compares every output and the readback byte on every clock.

// File: rtl/ib_pkg.sv
package ib_pkg;
    localparam int unsigned HOST_AW   = 4;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WORD_B    = 4;
    localparam int unsigned ADDR_B    = 2;
    localparam int unsigned WORD_W    = WORD_B * BYTE_W;
    localparam int unsigned IB_AW     = ADDR_B * BYTE_W;

    localparam logic [HOST_AW-1:0] OFF_WVAL0 = 4'd0;
    localparam logic [HOST_AW-1:0] OFF_WADR0 = 4'd4;
    localparam logic [HOST_AW-1:0] OFF_RADR0 = 4'd6;
    localparam logic [HOST_AW-1:0] OFF_CTRL  = 4'd8;
    localparam logic [HOST_AW-1:0] OFF_RVAL0 = 4'd9;

    localparam int unsigned CTRL_GO  = 0;
    localparam int unsigned CTRL_DIR = 1;

    typedef struct packed {
        logic [WORD_B-1:0][BYTE_W-1:0] wval;
        logic [ADDR_B-1:0][BYTE_W-1:0] wadr;
        logic [ADDR_B-1:0][BYTE_W-1:0] radr;
        logic [WORD_B-1:0][BYTE_W-1:0] rval;
    } stage_t;
endpackage

// File: rtl/ib_stage_regs.sv
module ib_stage_regs
    import ib_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_we,
    input  logic [HOST_AW-1:0]   h_addr,
    input  logic [BYTE_W-1:0]    h_wdata,
    output logic [BYTE_W-1:0]    h_rdata,
    input  logic                 busy_i,
    input  logic                 dir_i,
    input  logic                 done_i,
    input  logic [WORD_W-1:0]    rdata_i,
    output logic                 launch_o,
    output logic                 launch_dir_o,
    output logic [WORD_W-1:0]    wval_o,
    output logic [IB_AW-1:0]     wadr_o,
    output logic [IB_AW-1:0]     radr_o
);
    stage_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        launch_o     = 1'b0;
        launch_dir_o = h_wdata[CTRL_DIR];
        if (h_we && !busy_i) begin
            if (h_addr < OFF_WADR0) begin
                st_d.wval[h_addr[1:0]] = h_wdata;
            end else if (h_addr < OFF_RADR0) begin
                st_d.wadr[h_addr[0]] = h_wdata;
            end else if (h_addr < OFF_CTRL) begin
                st_d.radr[h_addr[0]] = h_wdata;
            end else if (h_addr == OFF_CTRL) begin
                launch_o = h_wdata[CTRL_GO];
            end
        end
        if (done_i && dir_i) begin
            st_d.rval = rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        h_rdata = '0;
        if (h_addr < OFF_WADR0) begin
            h_rdata = st_q.wval[h_addr[1:0]];
        end else if (h_addr < OFF_RADR0) begin
            h_rdata = st_q.wadr[h_addr[0]];
        end else if (h_addr < OFF_CTRL) begin
            h_rdata = st_q.radr[h_addr[0]];
        end else if (h_addr == OFF_CTRL) begin
            h_rdata = {{(BYTE_W-2){1'b0}}, dir_i, busy_i};
        end else if (h_addr < OFF_RVAL0 + WORD_B) begin
            h_rdata = st_q.rval[2'(h_addr - OFF_RVAL0)];
        end
    end

    assign wval_o = st_q.wval;
    assign wadr_o = st_q.wadr;
    assign radr_o = st_q.radr;

    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && h_we) |=> ($stable(st_q.wval) && $stable(st_q.wadr) && $stable(st_q.radr))); // R7
    AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && dir_i) |=> (st_q.rval == $past(rdata_i))); // R4
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_i && dir_i) |=> $stable(st_q.rval)); // R4
endmodule

// File: rtl/ib_access_seq.sv
module ib_access_seq #(
    parameter int unsigned LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic launch_dir_i,
    output logic busy_o,
    output logic dir_o,
    output logic stb_o
);
    localparam int unsigned CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    typedef struct packed {
        logic          busy;
        logic          dir;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d  = sq_q;
        stb_o = sq_q.busy && (sq_q.cnt == LAST);
        if (sq_q.busy) begin
            if (stb_o) begin
                sq_d.busy = 1'b0;
                sq_d.cnt  = '0;
            end else begin
                sq_d.cnt  = sq_q.cnt + 1'b1;
            end
        end else if (launch_i) begin
            sq_d.busy = 1'b1;
            sq_d.dir  = launch_dir_i;
            sq_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign busy_o = sq_q.busy;
    assign dir_o  = sq_q.dir;

    AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !busy_o) |=> busy_o); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> (!busy_o && !stb_o)); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !launch_i) |=> (!busy_o && $stable(dir_o))); // R5
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge
    import ib_pkg::*;
#(
    parameter int unsigned LATENCY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_we,
    input  logic [3:0]  h_addr,
    input  logic [7:0]  h_wdata,
    output logic [7:0]  h_rdata,
    output logic        ib_stb,
    output logic        ib_we,
    output logic [15:0] ib_addr,
    output logic [31:0] ib_wdata,
    input  logic [31:0] ib_rdata
);
    logic              busy, dir, launch, launch_dir;
    logic [IB_AW-1:0]  wadr, radr;

    ib_stage_regs u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_we         (h_we),
        .h_addr       (h_addr),
        .h_wdata      (h_wdata),
        .h_rdata      (h_rdata),
        .busy_i       (busy),
        .dir_i        (dir),
        .done_i       (ib_stb),
        .rdata_i      (ib_rdata),
        .launch_o     (launch),
        .launch_dir_o (launch_dir),
        .wval_o       (ib_wdata),
        .wadr_o       (wadr),
        .radr_o       (radr)
    );

    ib_access_seq #(.LATENCY(LATENCY)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .launch_dir_i (launch_dir),
        .busy_o       (busy),
        .dir_o        (dir),
        .stb_o        (ib_stb)
    );

    assign ib_we   = ib_stb && !dir;
    assign ib_addr = dir ? radr : wadr;

    AST_STB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ib_stb |-> busy); // R8
endmodule

// File: tb/ind_bridge_tb_top.sv
module ind_bridge_tb_top;
    localparam int PERIOD = 10;
    localparam int LAT    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0;
    logic [3:0]  h_addr = '0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        ib_stb, ib_we;
    logic [15:0] ib_addr;
    logic [31:0] ib_wdata, ib_rdata;

    int nchk = 0, nfail = 0, nstb = 0, nlaunch = 0;

    logic [31:0] mem  [256];
    logic [31:0] mmem [256];
    logic [7:0]  mregs [16];
    logic        mdir;
    int          mrem;

    always #(PERIOD/2) clk = ~clk;

    ind_bridge #(.LATENCY(LAT)) dut_i (.*);

    assign ib_rdata = mem[ib_addr[7:0]];
    always @(posedge clk) if (ib_stb && ib_we) mem[ib_addr[7:0]] <= ib_wdata;
    always @(posedge clk) if (rst_n && ib_stb) nstb++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rb(input logic [3:0] a);
        if (a <= 4'd7 || (a >= 4'd9 && a <= 4'd12)) return mregs[a];
        if (a == 4'd8) return {6'b0, mdir, mrem != 0};
        return 8'h00;
    endfunction

    // behavioural reference model, stepped and compared every clock
    always begin
        @(posedge clk);
        if (!rst_n) begin
            foreach (mregs[i]) mregs[i] = 8'h00;
            mdir = 1'b0; mrem = 0;
        end else if (mrem > 0) begin
            if (mrem == 1) begin
                if (mdir) begin
                    for (int b = 0; b < 4; b++) mregs[9+b] = mmem[mregs[6]][8*b +: 8];
                end else begin
                    mmem[mregs[4]] = {mregs[3], mregs[2], mregs[1], mregs[0]};
                end
            end
            mrem--;
        end else if (h_we) begin
            if (h_addr <= 4'd7) mregs[h_addr] = h_wdata;
            else if (h_addr == 4'd8 && h_wdata[0]) begin
                mdir = h_wdata[1]; mrem = LAT; nlaunch++;
            end
        end
        #1;
        if (rst_n) begin
            chk("R8 strobe", {31'b0, ib_stb}, {31'b0, mrem == 1});
            if (mrem == 1) begin
                if (mdir) begin
                    chk("R4 dir", {31'b0, ib_we}, 32'd0);
                    chk("R4 addr", {16'b0, ib_addr}, {16'b0, mregs[7], mregs[6]});
                end else begin
                    chk("R3 dir", {31'b0, ib_we}, 32'd1);
                    chk("R3 addr", {16'b0, ib_addr}, {16'b0, mregs[5], mregs[4]});
                    chk("R3 data", ib_wdata, {mregs[3], mregs[2], mregs[1], mregs[0]});
                end
            end
            if (h_addr == 4'd8)      chk("R6 ctrl readback", {24'b0, h_rdata}, {24'b0, exp_rb(h_addr)});
            else if (h_addr > 4'd12) chk("R9 unused readback", {24'b0, h_rdata}, 32'd0);
            else if (h_addr >= 4'd9) chk("R4 result readback", {24'b0, h_rdata}, {24'b0, exp_rb(h_addr)});
            else                     chk("R2 stage readback", {24'b0, h_rdata}, {24'b0, exp_rb(h_addr)});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        h_addr = a;
        #1;
        chk(tag, {24'b0, h_rdata}, {24'b0, e});
    endtask

    task automatic settle();
        repeat (LAT + 2) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed;
        logic [7:0] a8;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = (32'(i) * 32'h01030507) ^ 32'hA55A0FF0;
            mmem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all offsets zero after reset
        for (int a = 0; a < 16; a++) peek(4'(a), 8'h00, "R1 reset readback");
        chk("R1 strobe idle", {31'b0, ib_stb}, 32'd0);

        // R2 staging, then R3 write
        wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44);
        wr(4, 8'h2A); wr(5, 8'h00); wr(6, 8'h2A); wr(7, 8'h00);
        peek(2, 8'h33, "R2 byte kept");
        peek(5, 8'h00, "R2 addr high kept");
        wr(8, 8'h01);
        settle();
        chk("R3 memory written", mem[8'h2A], 32'h44332211);

        // R4 read back the same word, R6 busy timing
        wr(8, 8'h03);
        peek(8, 8'h03, "R6 busy set");
        repeat (LAT) @(negedge clk);
        #1 chk("R6 busy cleared", {24'b0, h_rdata}, 32'h02);
        peek(9, 8'h11, "R4 result byte0");
        peek(12, 8'h44, "R4 result byte3");

        // R5: write then no-op command
        wr(6, 8'h05);
        wr(8, 8'h01); settle();
        wr(8, 8'h02);
        peek(8, 8'h00, "R5 no-op command");

        // R7: writes during busy are dropped
        wr(8, 8'h03);
        wr(0, 8'hEE); wr(6, 8'h77); wr(8, 8'h01);
        settle();
        peek(0, 8'h11, "R7 wval ignored");
        peek(6, 8'h05, "R7 radr ignored");
        peek(9, mem[5][7:0], "R7 result from original addr");

        // R9: writes to result / unused offsets ignored
        wr(9, 8'hFF); wr(13, 8'h5C); wr(15, 8'h5C);
        peek(13, 8'h00, "R9 unused offset");
        peek(9, mem[5][7:0], "R9 result not host-writable");

        // mixed traffic, back-to-back commands while busy
        seed = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            a8 = seed[23:16];
            wr(4'(seed[3:0] % 8), a8);
            wr(8, {6'b0, seed[9], seed[10] | seed[11]});
            if (seed[12]) settle();
        end
        settle();
        chk("R8 one strobe per command", 32'(nstb), 32'(nlaunch));
        summary();
    end
endmodule